// File: doc/BRIEF.md
# Dead-Time Push-Pull Output Sequencer

This block is the digital heart of a primary-side push-pull driver. A clock-counted oscillator splits every period into a charge phase and a discharge phase, and each length is a programmable number of system clocks. During a charge phase one of the two gate-drive outputs pulses high. A toggle element picks which output gets each pulse, so the two outputs alternate and each one runs at half the oscillator rate. During the discharge phase both outputs are low. The dead time between the two outputs is therefore exactly the discharge length, and the sync output is high for that same interval.

A fault and soft-start sequencer sits beside this block. It supplies an enable and a per-period blanking request. It counts periods using a one-clock strobe that this block raises at the start of each discharge phase. The oscillator keeps running while enable is low, so the sequencer can time its retry delay in oscillator periods.

The controller has two states. In CHARGE a pulse may be driven. In DEAD both outputs are held low. Two transitions link them. END_CHARGE is taken when the charge count runs out, and it moves the block from CHARGE to DEAD. END_DEAD is taken when the discharge count runs out, and it moves the block from DEAD back to CHARGE, which starts a new period. Reset places the controller in DEAD with an expired count, so END_DEAD is taken on the first clock after reset.

Top module: `pushpull_deadtime_seq`

## Requirements
- R1: While reset is asserted, out_a, out_b, sync_o and period_strobe are all 0. The first pulse driven after reset appears on out_a.
- R2: One period lasts chg_len + dead_len clocks: chg_len clocks of CHARGE followed by dead_len clocks of DEAD. A length of 0 counts as 1. The first CHARGE phase begins with the outputs registered on the first clock edge after reset is released.
- R3: out_a and out_b are never high together, and both are low for the whole DEAD phase. The dead time therefore equals dead_len clocks.
- R4: sync_o is high on exactly the DEAD-phase clocks during which enable was high at the registering edge. It is low at all other times.
- R5: The pulses strictly alternate between out_a and out_b. The steering toggles at END_CHARGE only if an output was actually driven high during that charge phase.
- R6: chg_len and dead_len are sampled only at the edge that starts a period (END_DEAD). A change at any other time has no effect until the next period.
- R7: An edge that samples enable low forces out_a, out_b and sync_o to 0. The period counting and period_strobe continue unchanged.
- R8: period_strobe is high for exactly one clock at the start of every DEAD phase, whatever the value of enable.
- R9: A charge phase pulses only if enable is high and blank is low at the edge that starts the period. The pulse is then driven on the clocks of that phase that see enable high. A period whose start sees blank high drives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chg_len | input | CNT_W | Charge-phase length in clocks (0 counts as 1) |
| dead_len | input | CNT_W | Discharge (dead-time) length in clocks (0 counts as 1) |
| enable | input | 1 | Output enable from the fault/soft-start sequencer |
| blank | input | 1 | Suppresses the pulse of the period that starts while it is high |
| out_a | output | 1 | First gate-drive output |
| out_b | output | 1 | Second gate-drive output |
| sync_o | output | 1 | High during the dead phase while enabled |
| period_strobe | output | 1 | One-clock strobe at the start of each dead phase |

## Verification
The assertions assume that enable, blank and both lengths are synchronous to clk and hold steady across each rising edge. The bench meets this by changing every input only on the falling edge. The assertions on phase exclusivity and strobe spacing also depend on a discharge phase of at least one clock, and the length clamp guarantees that. The stimulus deliberately includes zero lengths, length changes in the middle of a period, and enable and blank changes that land inside charge phases, so the clamp and the sampling rules are exercised.

// File: rtl/dtp_pkg.sv
package dtp_pkg;
    typedef enum logic {
        PH_CHARGE = 1'b0,
        PH_DEAD   = 1'b1
    } phase_e;
endpackage

// File: rtl/dtp_phase_timer.sv
module dtp_phase_timer
    import dtp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] chg_len,
    input  logic [CNT_W-1:0] dead_len,
    output phase_e           phase_q,
    output phase_e           nxt_phase,
    output logic             period_start,
    output logic             dead_start
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] nxt_cnt;
    logic [CNT_W-1:0] dead_lat_q;

    // last count index for a length, zero treated as one clock
    function automatic logic [CNT_W-1:0] last_idx(input logic [CNT_W-1:0] len);
        return (len == '0) ? '0 : len - 1'b1;
    endfunction

    assign period_start = (phase_q == PH_DEAD)   && (cnt_q == '0);
    assign dead_start   = (phase_q == PH_CHARGE) && (cnt_q == '0);

    always_comb begin
        nxt_phase = phase_q;
        nxt_cnt   = cnt_q - 1'b1;
        unique case (phase_q)
            PH_CHARGE: begin
                if (cnt_q == '0) begin          // END_CHARGE
                    nxt_phase = PH_DEAD;
                    nxt_cnt   = last_idx(dead_lat_q);
                end
            end
            PH_DEAD: begin
                if (cnt_q == '0) begin          // END_DEAD
                    nxt_phase = PH_CHARGE;
                    nxt_cnt   = last_idx(chg_len);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_DEAD;
            cnt_q      <= '0;
            dead_lat_q <= '0;
        end else begin
            phase_q <= nxt_phase;
            cnt_q   <= nxt_cnt;
            if (period_start) begin
                dead_lat_q <= dead_len;
            end
        end
    end

    assert_dead_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DEAD && cnt_q != '0) |=> (phase_q == PH_DEAD));

    assert_charge_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_CHARGE && cnt_q != '0) |=> (phase_q == PH_CHARGE));
endmodule

// File: rtl/dtp_steer.sv
module dtp_steer (
    input  logic clk,
    input  logic rst_n,
    input  logic period_start,
    input  logic dead_start,
    input  logic arm_req,
    input  logic drive_now,
    output logic arm_next,
    output logic sel_b
);
    logic armed_q;
    logic fired_q;

    assign arm_next = period_start ? arm_req : armed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            fired_q <= 1'b0;
            sel_b   <= 1'b0;
        end else begin
            armed_q <= arm_next;
            if (period_start) begin
                fired_q <= drive_now;
            end else if (drive_now) begin
                fired_q <= 1'b1;
            end
            if (dead_start && fired_q) begin
                sel_b <= ~sel_b;
            end
        end
    end

    assert_flip_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sel_b) |-> ($past(dead_start) && $past(fired_q)));
endmodule

// File: rtl/pushpull_deadtime_seq.sv
module pushpull_deadtime_seq
    import dtp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] chg_len,
    input  logic [CNT_W-1:0] dead_len,
    input  logic             enable,
    input  logic             blank,
    output logic             out_a,
    output logic             out_b,
    output logic             sync_o,
    output logic             period_strobe
);
    phase_e phase_q;
    phase_e nxt_phase;
    logic   period_start;
    logic   dead_start;
    logic   arm_next;
    logic   sel_b;
    logic   drive_now;

    dtp_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .chg_len      (chg_len),
        .dead_len     (dead_len),
        .phase_q      (phase_q),
        .nxt_phase    (nxt_phase),
        .period_start (period_start),
        .dead_start   (dead_start)
    );

    dtp_steer u_steer (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_start (period_start),
        .dead_start   (dead_start),
        .arm_req      (enable && !blank),
        .drive_now    (drive_now),
        .arm_next     (arm_next),
        .sel_b        (sel_b)
    );

    assign drive_now = enable && (nxt_phase == PH_CHARGE) && arm_next;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_a         <= 1'b0;
            out_b         <= 1'b0;
            sync_o        <= 1'b0;
            period_strobe <= 1'b0;
        end else begin
            out_a         <= drive_now && !sel_b;
            out_b         <= drive_now &&  sel_b;
            sync_o        <= enable && (nxt_phase == PH_DEAD);
            period_strobe <= dead_start;
        end
    end

    assert_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_a && out_b));

    assert_sync_dead_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |-> (!out_a && !out_b));

    assert_en_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!out_a && !out_b && !sync_o));

    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        period_strobe |=> !period_strobe);

    assert_strobe_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
        period_strobe |-> (phase_q == PH_DEAD));
endmodule

// File: tb/pushpull_deadtime_seq_test.sv
module pushpull_deadtime_seq_test;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] chg_len = 8'd3;
    logic [CNT_W-1:0] dead_len = 8'd2;
    logic             enable = 1'b0;
    logic             blank = 1'b0;
    logic             out_a, out_b, sync_o, period_strobe;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    pushpull_deadtime_seq #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .chg_len(chg_len), .dead_len(dead_len),
        .enable(enable), .blank(blank), .out_a(out_a), .out_b(out_b),
        .sync_o(sync_o), .period_strobe(period_strobe)
    );

    // Expected behaviour built from the requirements: position in period
    bit m_started, m_armed, m_fired, m_sel;
    int m_pos, m_c, m_d;
    bit ea, eb, es, et;
    int last_pulse = -1;
    int alt_err = 0;
    bit pa_q, pb_q;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_started = 0; m_armed = 0; m_fired = 0; m_sel = 0;
            m_pos = 0; m_c = 1; m_d = 1;
            ea = 0; eb = 0; es = 0; et = 0;
        end else begin
            if (!m_started || m_pos == m_c + m_d - 1) begin
                m_started = 1;
                m_c = (chg_len == 0) ? 1 : int'(chg_len);
                m_d = (dead_len == 0) ? 1 : int'(dead_len);
                m_pos = 0;
                m_armed = enable && !blank;
                m_fired = 0;
            end else begin
                m_pos++;
            end
            if (m_pos == m_c && m_fired) m_sel = ~m_sel;
            ea = enable && (m_pos < m_c) && m_armed && !m_sel;
            eb = enable && (m_pos < m_c) && m_armed &&  m_sel;
            if (ea || eb) m_fired = 1;
            es = enable && (m_pos >= m_c);
            et = (m_pos == m_c);
        end
    end

    // Alternation monitor (R5) on observed rising pulses
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_a && !pa_q) begin
                if (last_pulse == 0) alt_err++;
                last_pulse = 0;
            end
            if (out_b && !pb_q) begin
                if (last_pulse == 1) alt_err++;
                last_pulse = 1;
            end
        end
        pa_q = out_a;
        pb_q = out_b;
    end

    task automatic window(input int n, input string tag);
        bit bad = 0;
        tests++;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!bad && {out_a, out_b, sync_o, period_strobe} != {ea, eb, es, et}) begin
                bad = 1;
                $display("FAIL %s cycle %0d: got a/b/sync/strb=%b expected %b",
                         tag, i, {out_a, out_b, sync_o, period_strobe}, {ea, eb, es, et});
            end
        end
        if (bad) fails++;
    endtask

    task automatic t_reset_R1();
        tests++;
        @(negedge clk);
        if ({out_a, out_b, sync_o, period_strobe} != 4'b0) begin
            fails++;
            $display("FAIL R1 reset: got %b expected 0000", {out_a, out_b, sync_o, period_strobe});
        end
        chg_len = 8'd3; dead_len = 8'd2; enable = 1'b1;
        rst_n = 1'b1;
        tests++;
        begin
            bit seen = 0;
            for (int i = 0; i < 10 && !seen; i++) begin
                @(negedge clk);
                if (out_a || out_b) begin
                    seen = 1;
                    if (!out_a) begin
                        fails++;
                        $display("FAIL R1 first pulse: got a=%b b=%b expected a=1 b=0", out_a, out_b);
                    end
                end
            end
            if (!seen) begin
                fails++;
                $display("FAIL R1 first pulse: got none expected out_a");
            end
        end
    endtask

    task automatic t_basic_R2_R3_R4();
        window(40, "R2/R3/R4/R8 basic 3+2");
        chg_len = 8'd1; dead_len = 8'd5;
        window(40, "R3 long dead 1+5");
        chg_len = 8'd10; dead_len = 8'd1;
        window(60, "R2/R8 long charge 10+1");
    endtask

    task automatic t_zero_len_R2();
        chg_len = 8'd0; dead_len = 8'd0;
        window(30, "R2 zero lengths clamp");
    endtask

    task automatic t_mid_change_R6();
        chg_len = 8'd6; dead_len = 8'd4;
        window(25, "R6 setup 6+4");
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chg_len = 8'(2 + k); dead_len = 8'(3 - k);
            window(17, "R6 mid-period length change");
        end
    endtask

    task automatic t_enable_R7();
        int strobes = 0;
        chg_len = 8'd5; dead_len = 8'd3;
        window(12, "R7 setup");
        enable = 1'b0;
        tests++;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (period_strobe) strobes++;
            if (out_a || out_b || sync_o) begin
                fails++;
                $display("FAIL R7 disabled: got a/b/sync=%b expected 000", {out_a, out_b, sync_o});
                break;
            end
        end
        tests++;
        if (strobes != 5) begin
            fails++;
            $display("FAIL R8 strobes while disabled: got %0d expected 5", strobes);
        end
        @(negedge clk);
        @(negedge clk);
        enable = 1'b1;
        window(40, "R7/R9 re-enable mid-period");
    endtask

    task automatic t_blank_R9();
        chg_len = 8'd2; dead_len = 8'd2;
        blank = 1'b1;
        window(9, "R9 blank held");
        blank = 1'b0;
        window(7, "R9 blank released");
        blank = 1'b1;
        @(negedge clk);
        blank = 1'b0;
        window(30, "R9 single-clock blank");
        for (int k = 0; k < 4; k++) begin
            blank = k[0];
            window(4, "R5/R9 alternating blank");
        end
        blank = 1'b0;
        window(20, "R5 after blanking");
    endtask

    task automatic t_alternation_R5();
        tests++;
        if (alt_err != 0) begin
            fails++;
            $display("FAIL R5 alternation: got %0d repeats expected 0", alt_err);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_R1();
        t_basic_R2_R3_R4();
        t_zero_len_R2();
        t_mid_change_R6();
        t_enable_R7();
        t_blank_R9();
        t_alternation_R5();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule